// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block turns a queue of tagged bytes into a bit-serial HDLC line signal. It reads from the show-ahead read port of an upstream FIFO. Each entry holds one byte and two tag bits. One tag marks the last byte of a packet. The other tells the transmitter to abort the packet that holds that byte. Because the packet boundaries travel inside the queue, several packets can be loaded back to back without any separate framing strobes.

On the line, each frame opens with the flag 0x7E and carries its bytes least significant bit first, one bit per bit-enable strobe. A zero is inserted after every run of five ones in the data and check fields. After the last byte of a packet come a 16-bit frame check sequence and a closing flag. That closing flag also opens the next frame when another packet is already waiting.

An abort-tagged byte, or a queue that runs dry in the middle of a packet, produces an abort of eight ones. The rest of that packet is then discarded. While nothing is queued, the line either holds ones or repeats flags, as set by a select input. The enable input lets the block start at the next byte boundary, and it stops only after a frame in flight has been closed.

Top module: `hdlcTxFramer`

## Requirements
- R1: After reset `txBit` is 1 and `fifoPop` is 0.
- R2: While `txEnable` is 0 and no frame is in progress, the line holds continuous ones and no byte is taken from the FIFO.
- R3: While enabled with the FIFO empty, `fillFlags` = 0 gives continuous ones and `fillFlags` = 1 gives repeated flags (line bits 0,1,1,1,1,1,1,0).
- R4: A frame starts with one flag, followed by its data bytes sent LSB first. Exactly one FIFO pop is made per byte. FIFO entry bits [7:0] are the data, bit 8 is the end-of-packet tag and bit 9 is the abort tag.
- R5: After five consecutive ones in the data or check fields (including runs that cross a byte boundary or reach the closing flag), a single zero is inserted. No zero is inserted in flags, abort ones or idle ones.
- R6: Directly after the end-of-packet byte, the block sends the ones-complement of CRC-16 (reflected polynomial 0x8408, preset 0xFFFF, computed LSB first over the data bytes), low byte first, followed by a closing flag.
- R7: When another packet is queued at the time of the closing flag, the next frame's first data byte follows that single flag directly.
- R8: An abort-tagged byte is not sent. Eight ones go out in its place, and the remaining bytes of that packet, up to and including its end-of-packet byte, are popped and never sent. The line then returns to the fill or the next frame.
- R9: If the FIFO is empty when the next data byte is due, eight ones are sent. Bytes of that packet that arrive later, up to and including its end-of-packet byte, are discarded, and the following packet is framed normally.
- R10: When `txEnable` falls during a frame, that frame completes with its check sequence and closing flag. After that the line holds ones and packets still queued stay in the FIFO.
- R11: When `txEnable` rises with data queued, the opening flag starts within eight bit times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe; one line bit per strobe |
| txEnable | input | 1 | Transmit enable |
| fillFlags | input | 1 | Fill select while empty: 0 ones, 1 flags |
| fifoEmpty | input | 1 | FIFO holds no entry |
| fifoData | input | 8 | Head byte of the FIFO |
| fifoEop | input | 1 | Head byte ends its packet |
| fifoAbort | input | 1 | Head byte aborts its packet |
| fifoPop | output | 1 | Consume the head entry at this clock edge |
| txBit | output | 1 | Serial line output |

## Verification
`txBit` takes its new value at the clock edge that samples `bitEn` high. The bench therefore records the line at the falling edge that follows each strobe, one recorded bit per strobe. A frame pop is raised in the same cycle as the strobe that starts that byte. Discard pops follow one per clock, so a dropped packet has left the FIFO long before the next byte boundary, eight strobes later.

Each expected bit stream is built from the requirements. It is compared from the first zero that is followed by a one, which is the opening flag's first bit after mark idle. The checks wait out the full frame length plus a margin before comparing, and FIFO occupancy is checked only after the frame or drop has ended.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  // Kind of byte-sized unit the datapath loads at a byte boundary
  typedef enum logic [2:0] {
    UNIT_ONES,
    UNIT_FLAG,
    UNIT_DATA,
    UNIT_FCSLO,
    UNIT_FCSHI,
    UNIT_ABORT
  } unitSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    unitSel_e unitSel;
    logic     crcInit;
  } ctrlStrobe_t;

endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadNow,
  input  logic        txEnable,
  input  logic        fillFlags,
  input  logic        fifoEmpty,
  input  logic        fifoEop,
  input  logic        fifoAbort,
  output ctrlStrobe_t strobe,
  output logic        fifoPop
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_FCSLO,
    ST_FCSHI,
    ST_CLOSE
  } txState_e;

  txState_e state, nextState;
  logic     dropping;
  logic     framePop;
  logic     setDrop;
  logic     canStart;
  logic     dropPop;

  assign canStart = txEnable && !dropping && !fifoEmpty;
  assign dropPop  = dropping && !fifoEmpty;
  assign fifoPop  = (loadNow && framePop) || dropPop;

  always_comb begin
    strobe.unitSel = UNIT_ONES;
    strobe.crcInit = 1'b0;
    nextState      = state;
    framePop       = 1'b0;
    setDrop        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (canStart) begin
          strobe.unitSel = UNIT_FLAG;
          strobe.crcInit = 1'b1;
          nextState      = ST_BODY;
        end else if (txEnable && fillFlags) begin
          strobe.unitSel = UNIT_FLAG;
        end
      end
      ST_BODY: begin
        if (fifoEmpty) begin
          strobe.unitSel = UNIT_ABORT;
          setDrop        = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          framePop = 1'b1;
          if (fifoAbort) begin
            strobe.unitSel = UNIT_ABORT;
            setDrop        = !fifoEop;
            nextState      = ST_IDLE;
          end else begin
            strobe.unitSel = UNIT_DATA;
            nextState      = fifoEop ? ST_FCSLO : ST_BODY;
          end
        end
      end
      ST_FCSLO: begin
        strobe.unitSel = UNIT_FCSLO;
        nextState      = ST_FCSHI;
      end
      ST_FCSHI: begin
        strobe.unitSel = UNIT_FCSHI;
        nextState      = ST_CLOSE;
      end
      ST_CLOSE: begin
        strobe.unitSel = UNIT_FLAG;
        strobe.crcInit = 1'b1;
        nextState      = canStart ? ST_BODY : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dropping <= 1'b0;
    end else begin
      if (loadNow) state <= nextState;
      if (loadNow && setDrop) dropping <= 1'b1;
      else if (dropPop && fifoEop) dropping <= 1'b0;
    end
  end

  // R4: never consume from an empty queue
  assert_pop_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPop |-> !fifoEmpty);

  // R8: discarding and framing never overlap
  assert_no_drop_in_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dropping && state == ST_BODY));

  // R8: discard ends with the end-of-packet byte
  assert_drop_stops_at_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && fifoPop && fifoEop) |=> !dropping);

  // R2: a disabled idle boundary stays idle
  assert_disabled_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loadNow && state == ST_IDLE && !txEnable) |=> state == ST_IDLE);

endmodule

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CRC_W     = 2 * DATA_W,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [DATA_W-1:0] FLAG_BYTE = 8'h7E,
  parameter int RUN_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitEn,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataByte,
  output logic              loadNow,
  output logic              txBit
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int RUN_W = $clog2(RUN_LIMIT + 1);

  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic              curStuff;
  logic [RUN_W-1:0]  onesRun;
  logic [CRC_W-1:0]  crcReg;
  logic              txBitQ;

  logic [DATA_W-1:0] unitByte;
  logic              unitStuffable;
  logic              stuffNow;
  logic              nextBit;
  logic              nextStuff;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < DATA_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign stuffNow = (onesRun == RUN_W'(RUN_LIMIT));
  assign loadNow  = bitEn && !stuffNow && (bitsLeft == '0);
  assign txBit    = txBitQ;

  always_comb begin
    unitByte      = '1;
    unitStuffable = 1'b0;
    case (strobe.unitSel)
      UNIT_FLAG:  unitByte = FLAG_BYTE;
      UNIT_DATA:  begin unitByte = dataByte;                     unitStuffable = 1'b1; end
      UNIT_FCSLO: begin unitByte = ~crcReg[DATA_W-1:0];          unitStuffable = 1'b1; end
      UNIT_FCSHI: begin unitByte = ~crcReg[CRC_W-1 -: DATA_W];   unitStuffable = 1'b1; end
      default:    unitByte = '1;
    endcase
  end

  assign nextBit   = loadNow ? unitByte[0]   : shReg[0];
  assign nextStuff = loadNow ? unitStuffable : curStuff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shReg    <= '0;
      bitsLeft <= '0;
      curStuff <= 1'b0;
      onesRun  <= '0;
      crcReg   <= '1;
      txBitQ   <= 1'b1;
    end else if (bitEn) begin
      if (stuffNow) begin
        txBitQ  <= 1'b0;
        onesRun <= '0;
      end else begin
        txBitQ  <= nextBit;
        onesRun <= (nextStuff && nextBit) ? onesRun + RUN_W'(1) : '0;
        if (loadNow) begin
          shReg    <= unitByte >> 1;
          bitsLeft <= CNT_W'(DATA_W - 1);
          curStuff <= unitStuffable;
          if (strobe.crcInit)                  crcReg <= '1;
          else if (strobe.unitSel == UNIT_DATA) crcReg <= crcStep(crcReg, dataByte);
        end else begin
          shReg    <= shReg >> 1;
          bitsLeft <= bitsLeft - CNT_W'(1);
        end
      end
    end
  end

  // R5: the run of stuffable ones never exceeds the limit
  assert_run_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    onesRun <= RUN_W'(RUN_LIMIT));

  // R5: a full run is followed by a zero on the line
  assert_stuff_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bitEn && stuffNow) |=> !txBit);

  // R4: a flag unit starts with a zero bit on the line
  assert_flag_leads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loadNow && strobe.unitSel == UNIT_FLAG) |=> !txBit);

  // R1: the line is static between strobes
  assert_line_static_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bitEn |=> $stable(txBit));

endmodule

// File: rtl/hdlcTxFramer.sv
module hdlcTxFramer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitEn,
  input  logic              txEnable,
  input  logic              fillFlags,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEop,
  input  logic              fifoAbort,
  output logic              fifoPop,
  output logic              txBit
);

  ctrlStrobe_t strobe;
  logic        loadNow;

  hdlc_tx_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .loadNow   (loadNow),
    .txEnable  (txEnable),
    .fillFlags (fillFlags),
    .fifoEmpty (fifoEmpty),
    .fifoEop   (fifoEop),
    .fifoAbort (fifoAbort),
    .strobe    (strobe),
    .fifoPop   (fifoPop)
  );

  hdlc_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bitEn    (bitEn),
    .strobe   (strobe),
    .dataByte (fifoData),
    .loadNow  (loadNow),
    .txBit    (txBit)
  );

endmodule

// File: tb/hdlcTxFramer_tb_top.sv
module hdlcTxFramer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bitEn = 1'b0;
  logic       txEnable = 1'b0;
  logic       fillFlags = 1'b0;
  logic       fifoEmpty = 1'b1;
  logic [7:0] fifoData = '0;
  logic       fifoEop = 1'b0;
  logic       fifoAbort = 1'b0;
  logic       fifoPop;
  logic       txBit;

  int nChecks = 0;
  int nFail = 0;

  logic [9:0] fifoQ[$];
  logic       popSeen = 1'b0;
  bit         capQ[$];
  bit         expQ[$];
  logic [7:0] pktQ[$];
  int         divCnt = 0;

  always #2 clk = ~clk;

  hdlcTxFramer dut_i (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .txEnable(txEnable),
    .fillFlags(fillFlags), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoEop(fifoEop), .fifoAbort(fifoAbort), .fifoPop(fifoPop), .txBit(txBit)
  );

  // FIFO model: pop taken at the edge, head updated at the falling edge
  always @(posedge clk) popSeen <= fifoPop;

  always @(negedge clk) begin
    if (popSeen && fifoQ.size() > 0) void'(fifoQ.pop_front());
    fifoEmpty = (fifoQ.size() == 0);
    fifoData  = fifoEmpty ? 8'h00 : fifoQ[0][7:0];
    fifoEop   = fifoEmpty ? 1'b0  : fifoQ[0][8];
    fifoAbort = fifoEmpty ? 1'b0  : fifoQ[0][9];
  end

  // bit strobe every fourth clock; record the line after each strobe
  always @(negedge clk) begin
    if (bitEn) capQ.push_back(txBit);
    divCnt = (divCnt + 1) % 4;
    bitEn  = rst_n && (divCnt == 0);
  end

  task automatic report(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitBits(int n);
    repeat (n * 4) @(posedge clk);
  endtask

  task automatic pushEntry(logic [7:0] d, bit eop, bit abt);
    fifoQ.push_back({abt, eop, d});
  endtask

  function automatic logic [15:0] crcUpd(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic expFlag();
    expQ.push_back(0);
    for (int i = 0; i < 6; i++) expQ.push_back(1);
    expQ.push_back(0);
  endtask

  task automatic expOnes(int n);
    for (int i = 0; i < n; i++) expQ.push_back(1);
  endtask

  // stuffed body of pktQ, optionally followed by the check sequence
  task automatic expBody(bit withFcs);
    logic [15:0] crc = 16'hFFFF;
    logic [7:0]  seq[$];
    int          run = 0;
    foreach (pktQ[k]) begin
      crc = crcUpd(crc, pktQ[k]);
      seq.push_back(pktQ[k]);
    end
    if (withFcs) begin
      seq.push_back(~crc[7:0]);
      seq.push_back(~crc[15:8]);
    end
    foreach (seq[k]) begin
      for (int i = 0; i < 8; i++) begin
        expQ.push_back(seq[k][i]);
        if (seq[k][i]) run++; else run = 0;
        if (run == 5) begin
          expQ.push_back(0);
          run = 0;
        end
      end
    end
  endtask

  function automatic int findSync();
    for (int i = 0; i + 1 < capQ.size(); i++)
      if (capQ[i] == 0 && capQ[i+1] == 1) return i;
    return -1;
  endfunction

  task automatic compareStream(string req, string what);
    int z = findSync();
    int badAt = -1;
    int act = 0;
    if (z < 0) begin
      report(0, req, {what, " no flag found"}, 0, 1);
      return;
    end
    foreach (expQ[i]) begin
      if (badAt < 0) begin
        if (z + i >= capQ.size()) begin
          badAt = i; act = 2;
        end else if (capQ[z+i] != expQ[i]) begin
          badAt = i; act = capQ[z+i];
        end
      end
    end
    report(badAt < 0, req, what, (badAt < 0) ? 0 : act,
           (badAt < 0) ? 0 : int'(expQ[badAt]));
    if (badAt >= 0) $display("  first mismatch at bit %0d", badAt);
  endtask

  task automatic checkAllOnes(string req, string what);
    int zeros = 0;
    foreach (capQ[i]) if (capQ[i] == 0) zeros++;
    report(zeros == 0 && capQ.size() > 0, req, what, zeros, 0);
  endtask

  task automatic runFrame(string req, string what);
    waitBits(expQ.size() + 30);
    compareStream(req, what);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    report(txBit == 1'b1, "R1", "txBit after reset", txBit, 1);
    report(fifoPop == 1'b0, "R1", "fifoPop after reset", fifoPop, 0);
  endtask

  task automatic testDisabled();
    txEnable = 0;
    pushEntry(8'h5A, 1, 0);
    capQ.delete();
    waitBits(30);
    checkAllOnes("R2", "line while disabled");
    report(fifoQ.size() == 1, "R2", "queue untouched while disabled", fifoQ.size(), 1);
    fifoQ.delete();
    waitBits(2);
  endtask

  task automatic testMarkIdle();
    txEnable = 1; fillFlags = 0;
    waitBits(10);
    capQ.delete();
    waitBits(30);
    checkAllOnes("R3", "mark idle fill");
  endtask

  task automatic testFlagFill();
    int z;
    bit ok = 1;
    fillFlags = 1;
    waitBits(10);
    capQ.delete();
    waitBits(48);
    z = findSync();
    expQ.delete();
    repeat (4) expFlag();
    if (z < 0 || z + 32 > capQ.size()) ok = 0;
    else foreach (expQ[i]) if (capQ[z+i] != expQ[i]) ok = 0;
    report(ok, "R3", "flag fill pattern (R5 no stuffing in flags)", ok, 1);
    fillFlags = 0;
    waitBits(20);
  endtask

  task automatic testSingleFrame();
    capQ.delete(); expQ.delete();
    pktQ = '{8'h12, 8'h34};
    pushEntry(8'h12, 0, 0); pushEntry(8'h34, 1, 0);
    expFlag(); expBody(1); expFlag(); expOnes(16);
    runFrame("R6", "single frame with check sequence (R4)");
    report(fifoQ.size() == 0, "R4", "one pop per byte", fifoQ.size(), 0);
  endtask

  task automatic testStuffing();
    capQ.delete(); expQ.delete();
    pktQ = '{8'hFF, 8'h1F, 8'hF8};
    pushEntry(8'hFF, 0, 0); pushEntry(8'h1F, 0, 0); pushEntry(8'hF8, 1, 0);
    expFlag(); expBody(1); expFlag(); expOnes(16);
    runFrame("R5", "zero insertion across bytes");
  endtask

  task automatic testBackToBack();
    capQ.delete(); expQ.delete();
    pushEntry(8'hA5, 0, 0); pushEntry(8'h3C, 1, 0); pushEntry(8'h7E, 1, 0);
    expFlag();
    pktQ = '{8'hA5, 8'h3C}; expBody(1);
    expFlag();
    pktQ = '{8'h7E}; expBody(1);
    expFlag(); expOnes(16);
    runFrame("R7", "two frames sharing one flag");
    report(fifoQ.size() == 0, "R7", "both packets consumed", fifoQ.size(), 0);
  endtask

  task automatic testAbortTag();
    capQ.delete(); expQ.delete();
    pushEntry(8'h11, 0, 0); pushEntry(8'h22, 0, 1);
    pushEntry(8'h33, 0, 0); pushEntry(8'h44, 1, 0);
    pushEntry(8'h55, 1, 0);
    expFlag();
    pktQ = '{8'h11}; expBody(0);
    expOnes(8);
    expFlag();
    pktQ = '{8'h55}; expBody(1);
    expFlag(); expOnes(16);
    runFrame("R8", "abort tag, drop, next frame");
    report(fifoQ.size() == 0, "R8", "aborted packet drained", fifoQ.size(), 0);
  endtask

  task automatic testUnderrun();
    capQ.delete(); expQ.delete();
    pushEntry(8'h9A, 0, 0);
    expFlag();
    pktQ = '{8'h9A}; expBody(0);
    expOnes(16);
    runFrame("R9", "underrun abort");
    capQ.delete();
    pushEntry(8'hBC, 1, 0);
    waitBits(20);
    report(fifoQ.size() == 0, "R9", "late bytes of underrun packet dropped", fifoQ.size(), 0);
    checkAllOnes("R9", "dropped bytes not sent");
    capQ.delete(); expQ.delete();
    pushEntry(8'h0F, 1, 0);
    expFlag();
    pktQ = '{8'h0F}; expBody(1);
    expFlag(); expOnes(8);
    runFrame("R9", "frame after underrun recovery");
  endtask

  task automatic testGracefulStop();
    capQ.delete(); expQ.delete();
    pushEntry(8'h01, 0, 0); pushEntry(8'h02, 0, 0); pushEntry(8'h03, 1, 0);
    pushEntry(8'h04, 1, 0);
    expFlag();
    pktQ = '{8'h01, 8'h02, 8'h03}; expBody(1);
    expFlag(); expOnes(24);
    while (findSync() < 0) @(posedge clk);
    waitBits(4);
    txEnable = 0;
    runFrame("R10", "frame completes after disable");
    report(fifoQ.size() == 1, "R10", "queued packet held while disabled", fifoQ.size(), 1);
  endtask

  task automatic testRestart();
    int z;
    capQ.delete(); expQ.delete();
    txEnable = 1;
    expFlag();
    pktQ = '{8'h04}; expBody(1);
    expFlag(); expOnes(8);
    runFrame("R11", "frame after re-enable");
    z = findSync();
    report(z >= 0 && z <= 8, "R11", "opening flag within eight bits", z, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    testReset();
    testDisabled();
    testMarkIdle();
    testFlagFill();
    testSingleFrame();
    testStuffing();
    testBackToBack();
    testAbortTag();
    testUnderrun();
    testGracefulStop();
    testRestart();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule